// File: doc/BRIEF.md
# Staged Four-Channel DAC Register Front End

This block sits between a 16-bit host register bus and four 12-bit digital-to-analog converter channels. The host writes a code for each channel and a shared range word into shadow registers. Those values reach the converter pins only when the host reads a commit address, so all four channels can move together on one chosen cycle. Channel codes and the range word are committed by reads at two separate addresses.

A general control register holds an enable bit and a staging bit. A small four-state machine, `dac_mode_fsm`, tracks them. The states are:

- `ST_IDLE` (disabled, direct)
- `ST_IDLE_STAGED` (disabled, staged)
- `ST_LIVE` (enabled, direct)
- `ST_LIVE_STAGED` (enabled, staged)

A write to the general control register is the only transition, and it moves the machine to the state named by write-data bits [1:0]. Reset enters `ST_IDLE`. In the direct states, a code write passes straight to the live channel register. In the staged states, the code waits for the commit read. In the disabled states the code pins are forced to zero, but every register keeps accepting writes.

Top module: `quad_dac_regif`

## Requirements
- R1: After reset all code outputs, polarity outputs and gain outputs are 0, and the block is in `ST_IDLE`, so it is disabled and direct.
- R2: A write to byte address 0x14, 0x16, 0x18 or 0x1A loads channel A, B, C or D respectively with write-data bits [11:0]; bits [15:12] are discarded. In a staged state this write leaves the code outputs unchanged.
- R3: In a staged state, a read at address 0x02 copies all four channel shadows to the live codes on the same clock edge.
- R4: A write to address 0x12 stores a range word without changing the polarity or gain outputs; a read at 0x12 commits the stored word to them.
- R5: In the committed range word, bit (7−i) is the bipolar select and bit (11−i) is the gain select of channel i, where A=0, B=1, C=2 and D=3; a 1 means bipolar or high gain.
- R6: A write to address 0x02 selects the mode: bit 1 is the enable and bit 0 is staging. The mode changes on that edge.
- R7: In a direct state, a code write appears on that channel's output after the write edge, and a read at 0x02 does not change any code.
- R8: While disabled, the code outputs read 0, but the shadow and live registers still update. Once the block is enabled, they show whatever was latched.
- R9: Every read returns 0 on the read-data bus at every address, including the two commit addresses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | 8 | Byte address |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data (always zero) |
| dac_code_o | output | 48 | Live codes; channel i at bits [12i+11:12i], A at i=0 |
| dac_bipolar_o | output | 4 | Bipolar select per channel, A at bit 0 |
| dac_gain_o | output | 4 | Gain select per channel, A at bit 0 |

## Verification
A wrong mode state shows up at the ports within one cycle of the next code write or commit read. In direct mode a staged-mode fault leaves the code pin stale after a write. In staged mode a direct-mode fault makes the code move before the commit. An enable fault forces the pins to zero, or fails to. A corrupted range shadow stays hidden until the 0x12 commit read and then appears on the polarity and gain pins on the following edge. The bench therefore keeps a model of every shadow and live register and compares all pins after every access.

// File: rtl/quad_dac_pkg.sv
package quad_dac_pkg;

    // Encoding is {enable, staged} so a control write maps directly to a state
    typedef enum logic [1:0] {
        ST_IDLE        = 2'b00,
        ST_IDLE_STAGED = 2'b01,
        ST_LIVE        = 2'b10,
        ST_LIVE_STAGED = 2'b11
    } dac_mode_e;

    // Byte addresses whose meaning the host software relies on
    localparam int unsigned OFS_GEN_CTRL  = 32'h02;
    localparam int unsigned OFS_RANGE     = 32'h12;
    localparam int unsigned OFS_CODE_BASE = 32'h14;
    localparam int unsigned CODE_STRIDE   = 2;

    // Bit positions in the general control word
    localparam int unsigned EN_BIT    = 1;
    localparam int unsigned STAGE_BIT = 0;

    // Range word layout: channel A sits at the top of each field
    localparam int unsigned POL_MSB  = 7;
    localparam int unsigned GAIN_MSB = 11;

endpackage

// File: rtl/dac_mode_fsm.sv
module dac_mode_fsm
    import quad_dac_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cfg_we,
    input  logic [1:0] cfg_bits,
    output logic       out_en,
    output logic       staged
);

    dac_mode_e state_q, state_d;

    always_comb begin
        state_d = state_q;
        if (cfg_we) begin
            unique case (cfg_bits)
                2'b00:   state_d = ST_IDLE;
                2'b01:   state_d = ST_IDLE_STAGED;
                2'b10:   state_d = ST_LIVE;
                default: state_d = ST_LIVE_STAGED;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        unique case (state_q)
            ST_IDLE:        begin out_en = 1'b0; staged = 1'b0; end
            ST_IDLE_STAGED: begin out_en = 1'b0; staged = 1'b1; end
            ST_LIVE:        begin out_en = 1'b1; staged = 1'b0; end
            default:        begin out_en = 1'b1; staged = 1'b1; end
        endcase
    end

    // R6
    mode_follows_cfg_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_we |=> (out_en == $past(cfg_bits[1])) && (staged == $past(cfg_bits[0])));

    // R6
    mode_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_we |=> $stable(out_en) && $stable(staged));

endmodule

// File: rtl/dac_chan_slice.sv
module dac_chan_slice #(
    parameter int unsigned CODE_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              hold_we,
    input  logic [CODE_W-1:0] wr_data,
    input  logic              staged,
    input  logic              commit_req,
    output logic [CODE_W-1:0] live_o
);

    logic [CODE_W-1:0] hold_q;
    logic [CODE_W-1:0] live_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hold_q <= '0;
            live_q <= '0;
        end else begin
            if (hold_we) hold_q <= wr_data;
            if (hold_we && !staged)
                live_q <= wr_data;
            else if (commit_req && staged)
                live_q <= hold_q;
        end
    end

    assign live_o = live_q;

    // R3
    commit_copies_shadow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (commit_req && staged && !hold_we) |=> live_q == $past(hold_q));

    // R7
    direct_commit_inert_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (commit_req && !staged && !hold_we) |=> $stable(live_q));

endmodule

// File: rtl/dac_range_ctrl.sv
module dac_range_ctrl
    import quad_dac_pkg::*;
#(
    parameter int unsigned NUM_CH = 4,
    localparam int unsigned LO_BIT = POL_MSB - NUM_CH + 1,
    localparam int unsigned FLD_W  = GAIN_MSB - LO_BIT + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              word_we,
    input  logic [FLD_W-1:0]  word_in,
    input  logic              commit_req,
    output logic [NUM_CH-1:0] bipolar_o,
    output logic [NUM_CH-1:0] gain_o
);

    logic [FLD_W-1:0] shadow_q;
    logic [FLD_W-1:0] live_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            shadow_q <= '0;
            live_q   <= '0;
        end else begin
            if (word_we)    shadow_q <= word_in;
            if (commit_req) live_q   <= shadow_q;
        end
    end

    for (genvar i = 0; i < NUM_CH; i++) begin : g_map
        assign bipolar_o[i] = live_q[POL_MSB - LO_BIT - i];
        assign gain_o[i]    = live_q[GAIN_MSB - LO_BIT - i];
    end

    // R4
    range_commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (commit_req && !word_we) |=> live_q == $past(shadow_q));

endmodule

// File: rtl/quad_dac_regif.sv
module quad_dac_regif
    import quad_dac_pkg::*;
#(
    parameter int unsigned NUM_CH = 4,
    parameter int unsigned CODE_W = 12,
    parameter int unsigned DATA_W = 16,
    parameter int unsigned ADDR_W = 8,
    localparam int unsigned LO_BIT = POL_MSB - NUM_CH + 1
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [ADDR_W-1:0]        bus_addr,
    input  logic                     bus_wr,
    input  logic                     bus_rd,
    input  logic [DATA_W-1:0]        bus_wdata,
    output logic [DATA_W-1:0]        bus_rdata,
    output logic [NUM_CH*CODE_W-1:0] dac_code_o,
    output logic [NUM_CH-1:0]        dac_bipolar_o,
    output logic [NUM_CH-1:0]        dac_gain_o
);

    logic              gen_we, range_we, range_commit, code_commit;
    logic              out_en, staged;
    logic [NUM_CH-1:0] chan_we;
    logic [NUM_CH*CODE_W-1:0] live_codes;

    assign gen_we       = bus_wr && (bus_addr == ADDR_W'(OFS_GEN_CTRL));
    assign code_commit  = bus_rd && (bus_addr == ADDR_W'(OFS_GEN_CTRL));
    assign range_we     = bus_wr && (bus_addr == ADDR_W'(OFS_RANGE));
    assign range_commit = bus_rd && (bus_addr == ADDR_W'(OFS_RANGE));

    // Every location is write-only from the host's view
    assign bus_rdata = '0;

    dac_mode_fsm u_mode (
        .clk      (clk),
        .rst_n    (rst_n),
        .cfg_we   (gen_we),
        .cfg_bits ({bus_wdata[EN_BIT], bus_wdata[STAGE_BIT]}),
        .out_en   (out_en),
        .staged   (staged)
    );

    for (genvar i = 0; i < NUM_CH; i++) begin : g_chan
        assign chan_we[i] = bus_wr &&
            (bus_addr == ADDR_W'(OFS_CODE_BASE + CODE_STRIDE * i));

        dac_chan_slice #(.CODE_W(CODE_W)) u_slice (
            .clk        (clk),
            .rst_n      (rst_n),
            .hold_we    (chan_we[i]),
            .wr_data    (bus_wdata[CODE_W-1:0]),
            .staged     (staged),
            .commit_req (code_commit),
            .live_o     (live_codes[i*CODE_W +: CODE_W])
        );

        assign dac_code_o[i*CODE_W +: CODE_W] =
            out_en ? live_codes[i*CODE_W +: CODE_W] : '0;

        // R7
        direct_write_visible_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (chan_we[i] && out_en && !staged && !gen_we)
            |=> dac_code_o[i*CODE_W +: CODE_W] == $past(bus_wdata[CODE_W-1:0]));
    end

    dac_range_ctrl #(.NUM_CH(NUM_CH)) u_range (
        .clk        (clk),
        .rst_n      (rst_n),
        .word_we    (range_we),
        .word_in    (bus_wdata[GAIN_MSB:LO_BIT]),
        .commit_req (range_commit),
        .bipolar_o  (dac_bipolar_o),
        .gain_o     (dac_gain_o)
    );

    // R2
    staged_write_hidden_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((|chan_we) && staged && !code_commit) |=> $stable(dac_code_o));

    // R4
    range_waits_commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !range_commit |=> $stable(dac_bipolar_o) && $stable(dac_gain_o));

    // R8
    disable_zeroes_codes_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (gen_we && !bus_wdata[EN_BIT]) |=> dac_code_o == '0);

endmodule

// File: tb/quad_dac_regif_bench.sv
`timescale 1ns/1ps
module quad_dac_regif_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [15:0] bus_wdata = '0;
    logic [15:0] bus_rdata;
    logic [47:0] dac_code_o;
    logic [3:0]  dac_bipolar_o;
    logic [3:0]  dac_gain_o;

    int checks = 0;
    int failures = 0;
    bit finished = 0;

    // model state
    logic [11:0] m_hold [4];
    logic [11:0] m_live [4];
    logic [15:0] m_rng_hold, m_rng_live;
    bit m_en, m_stg;

    always #4 clk = ~clk;

    quad_dac_regif u_quad_dac_regif (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .dac_code_o(dac_code_o), .dac_bipolar_o(dac_bipolar_o),
        .dac_gain_o(dac_gain_o)
    );

    function automatic logic [47:0] exp_codes();
        logic [47:0] v = '0;
        for (int i = 0; i < 4; i++) v[i*12 +: 12] = m_en ? m_live[i] : 12'h0;
        return v;
    endfunction

    function automatic logic [3:0] exp_bip();
        logic [3:0] v;
        for (int i = 0; i < 4; i++) v[i] = m_rng_live[7-i];
        return v;
    endfunction

    function automatic logic [3:0] exp_gain();
        logic [3:0] v;
        for (int i = 0; i < 4; i++) v[i] = m_rng_live[11-i];
        return v;
    endfunction

    task automatic check_pins(input string tag);
        checks++;
        if (dac_code_o !== exp_codes() || dac_bipolar_o !== exp_bip() ||
            dac_gain_o !== exp_gain()) begin
            failures++;
            $display("FAIL %s: code=%h bip=%b gain=%b expected code=%h bip=%b gain=%b",
                     tag, dac_code_o, dac_bipolar_o, dac_gain_o,
                     exp_codes(), exp_bip(), exp_gain());
        end
    endtask

    task automatic model_wr(input logic [7:0] a, input logic [15:0] d);
        if (a == 8'h02) begin m_en = d[1]; m_stg = d[0]; end
        else if (a == 8'h12) m_rng_hold = d;
        else if (a >= 8'h14 && a <= 8'h1A && a[0] == 1'b0) begin
            m_hold[(a - 8'h14) >> 1] = d[11:0];
            if (!m_stg) m_live[(a - 8'h14) >> 1] = d[11:0];
        end
    endtask

    task automatic model_rd(input logic [7:0] a);
        if (a == 8'h02 && m_stg) for (int i = 0; i < 4; i++) m_live[i] = m_hold[i];
        if (a == 8'h12) m_rng_live = m_rng_hold;
    endtask

    task automatic do_wr(input logic [7:0] a, input logic [15:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
        model_wr(a, d);
    endtask

    task automatic do_rd(input logic [7:0] a, input string tag);
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1;
        #1;
        checks++;
        if (bus_rdata !== 16'h0) begin
            failures++;
            $display("FAIL %s R9: rdata=%h expected 0000 at addr %h", tag, bus_rdata, a);
        end
        @(negedge clk);
        bus_rd = 1'b0;
        model_rd(a);
    endtask

    initial begin
        #(8 * 150000);
        if (!finished) begin
            failures++;
            $display("FAIL watchdog: run hung, actual timeout expected completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5EED_0042));
        for (int i = 0; i < 4; i++) begin m_hold[i] = '0; m_live[i] = '0; end
        m_rng_hold = '0; m_rng_live = '0; m_en = 0; m_stg = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check_pins("R1 reset state");

        // R6: enable + staged
        do_wr(8'h02, 16'h0003);
        // R2: staged writes stay hidden, upper bits dropped
        do_wr(8'h14, 16'hF123);
        do_wr(8'h16, 16'h0456);
        do_wr(8'h18, 16'h0789);
        do_wr(8'h1A, 16'h0ABC);
        check_pins("R2 staged writes hidden");
        // R3: commit all
        do_rd(8'h02, "R3");
        check_pins("R3 commit copies all channels");
        if (dac_code_o[11:0] !== 12'h123) begin
            failures++;
            $display("FAIL R2 high bits: chA=%h expected 123", dac_code_o[11:0]);
        end
        checks++;

        // R4 / R5
        do_wr(8'h12, 16'h0880);
        check_pins("R4 range write hidden");
        do_rd(8'h12, "R4");
        check_pins("R5 channel A bipolar and gain");
        if (dac_bipolar_o !== 4'b0001 || dac_gain_o !== 4'b0001) begin
            failures++;
            $display("FAIL R5: bip=%b gain=%b expected 0001 0001", dac_bipolar_o, dac_gain_o);
        end
        checks++;
        do_wr(8'h12, 16'h0450);
        do_rd(8'h12, "R5");
        check_pins("R5 mixed bits");

        // R7: direct mode
        do_wr(8'h02, 16'h0002);
        do_wr(8'h16, 16'h0DEF);
        check_pins("R7 direct write visible");
        do_wr(8'h18, 16'h0111);
        do_rd(8'h02, "R7");
        check_pins("R7 commit inert in direct");

        // R8: disabled, registers still update
        do_wr(8'h02, 16'h0001);
        check_pins("R8 disabled zero");
        do_wr(8'h1A, 16'h0FFF);
        do_rd(8'h02, "R8");
        check_pins("R8 disabled after commit");
        do_wr(8'h02, 16'h0003);
        check_pins("R8 enable shows latched codes");
        do_rd(8'h06, "R9");
        check_pins("R9 other read inert");

        // random mix
        for (int n = 0; n < 400; n++) begin
            int unsigned pick = $urandom % 8;
            int unsigned ch = $urandom % 4;
            logic [15:0] d = 16'($urandom);
            case (pick)
                0, 1: do_wr(8'(8'h14 + 2 * ch), d);
                2:    do_rd(8'h02, "R3 random");
                3:    do_wr(8'h12, d);
                4:    do_rd(8'h12, "R4 random");
                5:    do_wr(8'h02, d);
                6:    do_rd(8'(8'h04 + 2 * ch), "R9 random");
                default: do_wr(8'h0A, d);
            endcase
            check_pins("R6 random sequence");
        end

        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule